// File: doc/BRIEF.md
# Trace Output Port Controller

This block sits between the debug-configuration registers and the pads of a trace output port. An IO-enable bit and a two-bit mode field come in as register-style inputs. From them the block chooses among three states: trace off, asynchronous trace on a single serial-wire output pin, or a synchronous port with a trace clock pin plus 1, 2 or 4 data pins. It drives one "assigned to trace" enable per pin, and any pin it does not claim stays free for general-purpose use.

The trace clock into the port stays low while the port is disabled. It connects to the system clock only after the IO-enable bit has been seen high at two consecutive clock edges. The block compares the protocol and port-size values that the debugger wrote against the selected mode, and raises a mismatch flag when they disagree. In synchronous modes it serializes parallel trace bytes across the active data pins and requests each next byte with a ready signal.

Top module: `trace_port_ctrl`

## Requirements
- R1: While `io_en` is 0, every pin enable, `tclk_gate` and `byte_ready` are 0 whatever `mode` holds, and all outputs are 0 after reset.
- R2: With `io_en`=1 and `mode`=00, only `swo_pin_en` is 1; `tclk_pin_en` and all `data_pin_en` bits are 0.
- R3: With `io_en`=1 and `mode` 01, 10 or 11, `tclk_pin_en` is 1, `swo_pin_en` is 0, and `data_pin_en` is 0001, 0011 or 1111 respectively; the other data pins stay released.
- R4: `tclk_gate` rises after the second consecutive rising clock edge at which `io_en` is sampled 1, and not earlier; any edge with `io_en`=0 restarts the count.
- R5: When `io_en` goes to 0, `tclk_gate`, all pin enables and `data_out` go to 0 in the same cycle, and a partly sent byte is dropped.
- R6: In synchronous modes a byte goes out least significant bits first. Each trace clock presents the next slice, with the lowest remaining bit on data pin 0 and the bits above it on pins 1..3. Unused data outputs read 0.
- R7: A byte takes 8, 4 or 2 cycles at widths 1, 2 or 4. `byte_ready` is 1 when the serializer is idle or shows its last slice. A byte offered with `byte_valid` while `byte_ready`=1 follows without a gap cycle. `byte_ready` is 0 unless `tclk_gate` is 1 in a synchronous mode.
- R8: In synchronous modes `cfg_mismatch` is 1 unless `protocol`=00 and `port_size` equals 0x1, 0x2 or 0x8 for mode 01, 10 or 11; any other size code flags.
- R9: In asynchronous mode `cfg_mismatch` is 1 unless `protocol` is 01 or 10.
- R10: `cfg_mismatch` is 0 while `io_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_en | input | 1 | Trace pin assignment enable |
| mode | input | 2 | 00 async serial-wire, 01/10/11 sync 1/2/4 data pins |
| port_size | input | 4 | Debugger-written port-size code |
| protocol | input | 2 | Debugger-written pin protocol |
| byte_in | input | 8 | Parallel trace byte |
| byte_valid | input | 1 | `byte_in` holds a byte to send |
| tclk_gate | output | 1 | Trace clock connected to system clock |
| swo_pin_en | output | 1 | Serial-wire output pin assigned to trace |
| tclk_pin_en | output | 1 | Trace clock pin assigned to trace |
| data_pin_en | output | 4 | Per data pin assigned-to-trace enables |
| data_out | output | 4 | Current data slice on the data pins |
| byte_ready | output | 1 | Serializer accepts a byte at the next edge |
| cfg_mismatch | output | 1 | Protocol or port size disagrees with mode |

## Verification
Pin enables, the mismatch flag and the drop on disable are combinational, so they are due in the same cycle as the input change. The clock gate is due after the second edge, and a loaded byte's first slice shows right after its loading edge. The bench changes inputs a quarter period after each rising edge and compares every output a quarter period after the next rising edge. The reference model advances at that edge, so each comparison sees the registered state and the still-held inputs that drove it.

// File: rtl/trace_port_pkg.sv
package trace_port_pkg;

   typedef enum logic [1:0] {
      TM_ASYNC = 2'b00,
      TM_SYNC1 = 2'b01,
      TM_SYNC2 = 2'b10,
      TM_SYNC4 = 2'b11
   } trace_mode_e;

   localparam logic [1:0] PROTO_PORT = 2'b00;
   localparam logic [1:0] PROTO_SW_A = 2'b01;
   localparam logic [1:0] PROTO_SW_B = 2'b10;

   // expected port-size code for a synchronous mode (one-hot style)
   function automatic logic [3:0] size_code(input logic [1:0] m);
      case (m)
         TM_SYNC1: size_code = 4'h1;
         TM_SYNC2: size_code = 4'h2;
         TM_SYNC4: size_code = 4'h8;
         default:  size_code = 4'h0;
      endcase
   endfunction

   // number of data pins a mode drives
   function automatic logic [2:0] lane_count(input logic [1:0] m);
      case (m)
         TM_SYNC1: lane_count = 3'd1;
         TM_SYNC2: lane_count = 3'd2;
         TM_SYNC4: lane_count = 3'd4;
         default:  lane_count = 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/trace_clk_gate.sv
module trace_clk_gate #(
   parameter int DELAY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic io_en,
   output logic gate
);

   logic hist_all;

   generate
      if (DELAY < 1) begin : g_bad_delay
         $error("trace_clk_gate: DELAY must be at least 1");
      end
      if (DELAY == 1) begin : g_single
         logic hist_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist_q <= 1'b0;
            else        hist_q <= io_en;
         end
         assign hist_all = hist_q;
      end else begin : g_chain
         logic [DELAY-1:0] hist_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist_q <= '0;
            else        hist_q <= {hist_q[DELAY-2:0], io_en};
         end
         // every stage high means io_en was sampled high DELAY edges in a row
         assign hist_all = &hist_q;
      end
   endgenerate

   assign gate = io_en & hist_all;

   p_gate_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !io_en |-> !gate);

   p_gate_history_r4: assert property (@(posedge clk) disable iff (!rst_n)
      gate |-> $past(io_en));

endmodule

// File: rtl/trace_pin_map.sv
module trace_pin_map
   import trace_port_pkg::*;
#(
   parameter int LANES_MAX = 4,
   localparam int LW = $clog2(LANES_MAX) + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 io_en,
   input  logic [1:0]           mode,
   output logic                 swo_en,
   output logic                 tclk_en,
   output logic                 sync_sel,
   output logic [LW-1:0]        lanes,
   output logic [LANES_MAX-1:0] data_en
);

   assign sync_sel = io_en && (mode != TM_ASYNC);
   assign swo_en   = io_en && (mode == TM_ASYNC);
   assign tclk_en  = sync_sel;
   assign lanes    = sync_sel ? LW'(lane_count(mode)) : '0;

   genvar i;
   generate
      for (i = 0; i < LANES_MAX; i++) begin : g_lane
         localparam logic [LW-1:0] IDX = LW'(i);
         assign data_en[i] = (IDX < lanes);
      end
   endgenerate

   p_swo_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      swo_en |-> (!tclk_en && data_en == '0));

   p_lane_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({1'b0, data_en} + 1'b1));

   p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !io_en |-> (!swo_en && !tclk_en && data_en == '0));

endmodule

// File: rtl/trace_cfg_check.sv
module trace_cfg_check
   import trace_port_pkg::*;
#(
   parameter int SIZE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_en,
   input  logic [1:0]        mode,
   input  logic [SIZE_W-1:0] port_size,
   input  logic [1:0]        protocol,
   output logic              mismatch
);

   logic async_bad;
   logic sync_bad;

   generate
      if (SIZE_W < 4) begin : g_bad_size
         $error("trace_cfg_check: SIZE_W must hold code 0x8");
      end
   endgenerate

   assign async_bad = (protocol != PROTO_SW_A) && (protocol != PROTO_SW_B);
   assign sync_bad  = (protocol != PROTO_PORT) ||
                      (port_size != SIZE_W'(size_code(mode)));

   always_comb begin
      if (!io_en)                  mismatch = 1'b0;
      else if (mode == TM_ASYNC)   mismatch = async_bad;
      else                         mismatch = sync_bad;
   end

   p_quiet_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !io_en |-> !mismatch);

   p_async_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (io_en && mode == TM_ASYNC && protocol == PROTO_SW_A) |-> !mismatch);

   p_sync_proto_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (io_en && mode != TM_ASYNC && protocol != PROTO_PORT) |-> mismatch);

endmodule

// File: rtl/trace_serializer.sv
module trace_serializer #(
   parameter int BYTE_W    = 8,
   parameter int LANES_MAX = 4,
   localparam int LW = $clog2(LANES_MAX) + 1,
   localparam int CW = $clog2(BYTE_W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 active,
   input  logic [LW-1:0]        lanes,
   input  logic [BYTE_W-1:0]    byte_in,
   input  logic                 byte_valid,
   output logic [LANES_MAX-1:0] data_out,
   output logic                 byte_ready
);

   logic              busy_q;
   logic [BYTE_W-1:0] shreg_q;
   logic [CW-1:0]     cnt_q;
   logic [LW-1:0]     lanes_q;
   logic [CW-1:0]     slices_m1;
   logic              last;
   logic              load;

   always_comb begin
      case (lanes)
         LW'(1):  slices_m1 = CW'(BYTE_W - 1);
         LW'(2):  slices_m1 = CW'(BYTE_W / 2 - 1);
         default: slices_m1 = CW'(BYTE_W / LANES_MAX - 1);
      endcase
   end

   assign last       = busy_q && (cnt_q == '0);
   assign byte_ready = active && (!busy_q || last);
   assign load       = byte_ready && byte_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         shreg_q <= '0;
         cnt_q   <= '0;
         lanes_q <= '0;
      end else if (!active) begin
         busy_q <= 1'b0;
      end else if (load) begin
         busy_q  <= 1'b1;
         shreg_q <= byte_in;
         cnt_q   <= slices_m1;
         lanes_q <= lanes;
      end else if (busy_q) begin
         if (last) begin
            busy_q <= 1'b0;
         end else begin
            shreg_q <= shreg_q >> lanes_q;
            cnt_q   <= cnt_q - 1'b1;
         end
      end
   end

   genvar i;
   generate
      for (i = 0; i < LANES_MAX; i++) begin : g_out
         localparam logic [LW-1:0] IDX = LW'(i);
         assign data_out[i] = active && busy_q && (IDX < lanes_q) && shreg_q[i];
      end
   endgenerate

   p_idle_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !byte_ready);

   p_byte_continues_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && busy_q && !last) |=> busy_q);

   p_drop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !busy_q);

endmodule

// File: rtl/trace_port_ctrl.sv
module trace_port_ctrl
   import trace_port_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int LANES_MAX = 4,
   parameter int SIZE_W    = 4,
   parameter int CLK_DELAY = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 io_en,
   input  logic [1:0]           mode,
   input  logic [SIZE_W-1:0]    port_size,
   input  logic [1:0]           protocol,
   input  logic [BYTE_W-1:0]    byte_in,
   input  logic                 byte_valid,
   output logic                 tclk_gate,
   output logic                 swo_pin_en,
   output logic                 tclk_pin_en,
   output logic [LANES_MAX-1:0] data_pin_en,
   output logic [LANES_MAX-1:0] data_out,
   output logic                 byte_ready,
   output logic                 cfg_mismatch
);

   localparam int LW = $clog2(LANES_MAX) + 1;

   generate
      if (LANES_MAX != 4) begin : g_bad_lanes
         $error("trace_port_ctrl: mode field encodes exactly 4 data pins");
      end
      if (BYTE_W % LANES_MAX != 0) begin : g_bad_byte
         $error("trace_port_ctrl: BYTE_W must divide by LANES_MAX");
      end
   endgenerate

   logic          sync_sel;
   logic [LW-1:0] lanes;

   trace_clk_gate #(.DELAY(CLK_DELAY)) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .io_en (io_en),
      .gate  (tclk_gate)
   );

   trace_pin_map #(.LANES_MAX(LANES_MAX)) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .io_en    (io_en),
      .mode     (mode),
      .swo_en   (swo_pin_en),
      .tclk_en  (tclk_pin_en),
      .sync_sel (sync_sel),
      .lanes    (lanes),
      .data_en  (data_pin_en)
   );

   trace_cfg_check #(.SIZE_W(SIZE_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .io_en     (io_en),
      .mode      (mode),
      .port_size (port_size),
      .protocol  (protocol),
      .mismatch  (cfg_mismatch)
   );

   trace_serializer #(.BYTE_W(BYTE_W), .LANES_MAX(LANES_MAX)) u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (tclk_gate && sync_sel),
      .lanes      (lanes),
      .byte_in    (byte_in),
      .byte_valid (byte_valid),
      .data_out   (data_out),
      .byte_ready (byte_ready)
   );

   p_ready_needs_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      byte_ready |-> (tclk_gate && tclk_pin_en));

   p_data_in_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (data_out & ~data_pin_en) == '0);

endmodule

// File: tb/trace_port_ctrl_bench.sv
module trace_port_ctrl_bench;

   localparam int CLK_P    = 10;
   localparam int WD_LIMIT = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       io_en = 1'b0;
   logic [1:0] mode = 2'b00;
   logic [3:0] port_size = 4'h1;
   logic [1:0] protocol = 2'b01;
   logic [7:0] byte_in = 8'h00;
   logic       byte_valid = 1'b0;

   logic       tclk_gate, swo_pin_en, tclk_pin_en, byte_ready, cfg_mismatch;
   logic [3:0] data_pin_en, data_out;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   int hi_cnt = 0;
   bit q[$];
   bit loaded = 0;

   always #(CLK_P/2) clk = ~clk;

   trace_port_ctrl u_trace_port_ctrl (
      .clk(clk), .rst_n(rst_n), .io_en(io_en), .mode(mode),
      .port_size(port_size), .protocol(protocol),
      .byte_in(byte_in), .byte_valid(byte_valid),
      .tclk_gate(tclk_gate), .swo_pin_en(swo_pin_en), .tclk_pin_en(tclk_pin_en),
      .data_pin_en(data_pin_en), .data_out(data_out),
      .byte_ready(byte_ready), .cfg_mismatch(cfg_mismatch)
   );

   function automatic int width_of(input logic [1:0] m);
      case (m)
         2'b01:   return 1;
         2'b10:   return 2;
         2'b11:   return 4;
         default: return 0;
      endcase
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s got=%h exp=%h at %0t", req, what, got, exp, $time);
      end
   endtask

   // reference model: advance one rising edge using the held inputs
   task automatic model_step();
      bit act, rdy;
      int w;
      loaded = 0;
      if (!rst_n) begin
         hi_cnt = 0;
         q.delete();
      end else begin
         w   = width_of(mode);
         act = io_en && hi_cnt >= 2 && mode != 2'b00;
         rdy = act && (q.size() <= w);
         if (act) begin
            for (int k = 0; k < w; k++) if (q.size() > 0) void'(q.pop_front());
            if (byte_valid && rdy) begin
               for (int b = 0; b < 8; b++) q.push_back(byte_in[b]);
               loaded = 1;
            end
         end else begin
            q.delete();
         end
         hi_cnt = io_en ? ((hi_cnt < 8) ? hi_cnt + 1 : hi_cnt) : 0;
      end
   endtask

   task automatic compare();
      bit gate_e, act;
      int w;
      logic [3:0] den_e, dat_e;
      logic mis_e;
      logic [3:0] code;
      gate_e = rst_n && io_en && hi_cnt >= 2;
      act    = gate_e && mode != 2'b00;
      w      = width_of(mode);
      den_e  = 4'h0;
      dat_e  = 4'h0;
      for (int i = 0; i < 4; i++) begin
         if (io_en && i < w) den_e[i] = 1'b1;
         if (act && i < w && i < q.size()) dat_e[i] = q[i];
      end
      case (mode)
         2'b01:   code = 4'h1;
         2'b10:   code = 4'h2;
         2'b11:   code = 4'h8;
         default: code = 4'h0;
      endcase
      if (!io_en)             mis_e = 1'b0;
      else if (mode == 2'b00) mis_e = !(protocol == 2'b01 || protocol == 2'b10);
      else                    mis_e = (protocol != 2'b00) || (port_size != code);

      chk(io_en ? "R4" : "R5", "tclk_gate", 8'(tclk_gate), 8'(gate_e));
      chk(io_en ? "R2" : "R1", "swo_pin_en", 8'(swo_pin_en), 8'(io_en && mode == 2'b00));
      chk(io_en ? "R3" : "R1", "tclk_pin_en", 8'(tclk_pin_en), 8'(io_en && mode != 2'b00));
      chk(io_en ? "R3" : "R1", "data_pin_en", 8'(data_pin_en), 8'(den_e));
      chk("R6", "data_out", 8'(data_out), 8'(dat_e));
      chk("R7", "byte_ready", 8'(byte_ready), 8'(act && q.size() <= w));
      chk(!io_en ? "R10" : (mode == 2'b00 ? "R9" : "R8"), "cfg_mismatch",
          8'(cfg_mismatch), 8'(mis_e));
   endtask

   task automatic cyc(input int n);
      for (int c = 0; c < n; c++) begin
         @(posedge clk);
         model_step();
         #(CLK_P/4);
         compare();
      end
   endtask

   task automatic send(input logic [7:0] b);
      byte_in    = b;
      byte_valid = 1'b1;
      do cyc(1); while (!loaded);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1: reset state at the ports
      chk("R1", "reset outputs",
          8'({tclk_gate, swo_pin_en, tclk_pin_en, byte_ready, cfg_mismatch}), 8'h00);
      chk("R1", "reset data", 8'({data_pin_en, data_out}), 8'h00);

      // R1 / R10: mode field ignored while disabled
      mode = 2'b11; protocol = 2'b11; port_size = 4'h3;
      cyc(3);

      // R2 / R9: asynchronous serial-wire mode
      io_en = 1'b0; cyc(1);
      mode = 2'b00; protocol = 2'b01; io_en = 1'b1;
      cyc(4);
      chk("R2", "async swo only", 8'({swo_pin_en, tclk_pin_en, data_pin_en}), 8'h20);
      protocol = 2'b10; cyc(2);
      protocol = 2'b00; cyc(1);
      chk("R9", "async with port protocol", 8'(cfg_mismatch), 8'h01);
      protocol = 2'b11; cyc(1);
      byte_valid = 1'b1; byte_in = 8'h77; cyc(2);
      chk("R7", "no ready in async", 8'(byte_ready), 8'h00);
      byte_valid = 1'b0;

      // R4 / R6 / R7: 1-bit synchronous
      io_en = 1'b0; cyc(2);
      mode = 2'b01; protocol = 2'b00; port_size = 4'h1; io_en = 1'b1;
      cyc(1);
      chk("R4", "gate after one edge", 8'(tclk_gate), 8'h00);
      cyc(1);
      chk("R4", "gate after two edges", 8'(tclk_gate), 8'h01);
      send(8'hA5); send(8'h3C); send(8'hF0);
      byte_valid = 1'b0;
      cyc(9);
      port_size = 4'h2; cyc(1);
      chk("R8", "size code disagrees", 8'(cfg_mismatch), 8'h01);
      port_size = 4'h3; cyc(1);
      port_size = 4'h1; cyc(1);
      chk("R8", "size code agrees", 8'(cfg_mismatch), 8'h00);

      // R4: a low edge restarts the gate count; 2-bit sync
      io_en = 1'b0; cyc(1);
      mode = 2'b10; port_size = 4'h2; io_en = 1'b1;
      cyc(1);
      io_en = 1'b0; cyc(1);
      io_en = 1'b1; cyc(1);
      chk("R4", "gate restarts", 8'(tclk_gate), 8'h00);
      send(8'h96); send(8'h5A);
      byte_valid = 1'b0;
      cyc(5);

      // R5: disable mid-byte
      send(8'hC3);
      byte_valid = 1'b0;
      cyc(1);
      io_en = 1'b0; cyc(1);
      chk("R5", "drop on disable",
          8'({tclk_gate, tclk_pin_en, data_pin_en, data_out[1:0]}), 8'h00);
      chk("R5", "data released", 8'(data_out), 8'h00);

      // R3 / R6 / R7: 4-bit sync
      mode = 2'b11; port_size = 4'h8; protocol = 2'b00; io_en = 1'b1;
      cyc(2);
      chk("R3", "four data pins", 8'(data_pin_en), 8'h0F);
      send(8'h1E); send(8'h7B); send(8'h80); send(8'hFF);
      byte_valid = 1'b0;
      cyc(4);
      protocol = 2'b01; cyc(1);
      chk("R8", "sync with serial protocol", 8'(cfg_mismatch), 8'h01);
      io_en = 1'b0; cyc(2);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R7 watchdog got=hung exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule